// File: doc/BRIEF.md
# Thirteen-Pin GPIO Controller with Edge Interrupts

This block is a general-purpose I/O controller for thirteen pins, reached through a small synchronous register bus. The bus has a 16-bit address, 8-bit data, and separate read and write strobes. Each pin has two byte registers.

The drive register holds the pin's settings:

- direction
- drive style (push-pull or open-drain)
- pull enable and pull choice
- the output level

The sense register holds the pin's edge-detect mode and returns the synchronized pin level.

Pin inputs pass through two synchronizer flops. An edge that matches the pin's mode sets a sticky status bit. The status bits are split into two groups of seven and six pins. Each group has a write-one-to-clear status register and a mask register. A single interrupt line is high while any status bit is set and not masked.

The block does not touch the pads or the pull resistors. It stores the drive and pull settings and exposes them as outputs, together with a per-pin output enable and output data.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, the drive and sense registers of every pin hold 0 in their writable fields. The group 0 mask reads 0x7F, the group 1 mask reads 0x3F, both status registers read 0, and `irq` is low.
- R2: The drive register of pin n is at 0x4E44+n. Bit 5 is direction (1 = output), bit 4 is drive style (1 = push-pull, 0 = open-drain), bit 3 is pull enable, bits 2:1 are the pull choice and bit 0 is the output level. Bits 7:6 read 0.
- R3: `pin_oe[n]` is high when direction is output and either push-pull is selected or bit 0 is 0. `pin_out[n]` equals bit 0 under push-pull and is 0 under open-drain. `drv_pushpull`, `pull_en` and `pull_sel` (two bits per pin, pin n at bits 2n+1:2n) copy bits 4, 3 and 2:1.
- R4: The sense register of pin n is at 0x4E51+n. Bits 2:1 hold the edge mode, bit 0 returns the synchronized pin level and ignores writes, and bits 7:3 read 0.
- R5: A change on `pin_in` appears in sense bit 0 for a read whose strobe is sampled on the third rising edge after the change, and not on the first or second.
- R6: Edge mode 00 sets no status, 01 sets status on a falling level, 10 on a rising level, and 11 on either.
- R7: Group 0 status is at 0x4E0B (pins 0..6 in bits 6:0) and group 1 status is at 0x4E0C (pins 7..12 in bits 5:0). A status bit stays set until a 1 is written to it, and writing 0 leaves it unchanged.
- R8: When a clearing write and a new qualifying edge for the same pin occur in the same cycle, the status bit stays set.
- R9: The group 0 mask is at 0x4E19 and the group 1 mask is at 0x4E1A, with a 1 blocking that pin. `irq` is high exactly when some status bit is set with its mask bit 0.
- R10: Unused high bits of the group registers (bit 7 of group 0, bits 7:6 of group 1) read 0, and writes to them are ignored.
- R11: Reads of any other address return 0, and writes to them change no register.
- R12: `bus_rdata` is loaded on the rising edge that samples `bus_rd` high, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 13 | Raw pin levels |
| pin_oe | output | 13 | Per-pin output enable |
| pin_out | output | 13 | Per-pin output data |
| drv_pushpull | output | 13 | Per-pin drive style, 1 = push-pull |
| pull_en | output | 13 | Per-pin pull enable |
| pull_sel | output | 26 | Per-pin pull choice, two bits each |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the strobe edge, so the pad outputs are compared at the next falling edge. Read data is due one edge after the strobe. A pin change reaches the sense level after two edges, and the status bit and `irq` after three. The bench changes pins and then waits four full cycles before it compares status or `irq`.

Two checks rely on exact edge counts. The read-back timing check issues back-to-back reads and expects the old, old, then new level. The coincidence check drives the clearing write exactly two falling edges after a pin change, so that it meets the edge pulse.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    localparam int DRV_W      = 6;
    localparam int DRV_LVL    = 0;
    localparam int DRV_PSEL_L = 1;
    localparam int DRV_PEN    = 3;
    localparam int DRV_PP     = 4;
    localparam int DRV_DIR    = 5;

endpackage

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense
    import gpio_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_raw,
    input  edge_mode_e mode,
    output logic       level,
    output logic       evt
);
    logic meta_q, sync_q, prev_q;
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
        unique case (mode)
            EDGE_OFF:  evt = 1'b0;
            EDGE_FALL: evt = fall;
            EDGE_RISE: evt = rise;
            default:   evt = rise | fall;
        endcase
    end

    assign level = sync_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive (
    input  logic dir_out,
    input  logic push_pull,
    input  logic lvl,
    output logic oe,
    output logic dout
);
    always_comb begin
        oe   = dir_out & (push_pull | ~lvl);
        dout = push_pull & lvl;
    end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int                NUM_PINS  = 13,
    parameter int                GRP0_PINS = 7,
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] DRV_BASE  = 16'h4E44,
    parameter logic [ADDR_W-1:0] SNS_BASE  = 16'h4E51,
    parameter logic [ADDR_W-1:0] STAT_BASE = 16'h4E0B,
    parameter logic [ADDR_W-1:0] MASK_BASE = 16'h4E19
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   drv_pushpull,
    output logic [NUM_PINS-1:0]   pull_en,
    output logic [2*NUM_PINS-1:0] pull_sel,
    output logic                  irq
);
    localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
    localparam int BIT_W     = $clog2(DATA_W);

    typedef struct packed {
        logic [NUM_PINS-1:0][DRV_W-1:0] drv;
        edge_mode_e [NUM_PINS-1:0]      mode;
        logic [NUM_PINS-1:0]            status;
        logic [NUM_PINS-1:0]            mask;
        logic [DATA_W-1:0]              rdata;
    } state_t;

    localparam state_t RST_STATE = '{
        drv:    '0,
        mode:   {NUM_PINS{EDGE_OFF}},
        status: '0,
        mask:   '1,
        rdata:  '0
    };

    state_t st_d, st_q;

    logic [NUM_PINS-1:0] level_w;
    logic [NUM_PINS-1:0] evt_w;
    logic [NUM_PINS-1:0] dir_w;

    // per-pin synchronizer, edge qualifier and pad control
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_edge_sense u_sense (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[p]),
            .mode    (st_q.mode[p]),
            .level   (level_w[p]),
            .evt     (evt_w[p])
        );

        gpio_pad_drive u_pad (
            .dir_out   (st_q.drv[p][DRV_DIR]),
            .push_pull (st_q.drv[p][DRV_PP]),
            .lvl       (st_q.drv[p][DRV_LVL]),
            .oe        (pin_oe[p]),
            .dout      (pin_out[p])
        );

        assign dir_w[p]            = st_q.drv[p][DRV_DIR];
        assign drv_pushpull[p]     = st_q.drv[p][DRV_PP];
        assign pull_en[p]          = st_q.drv[p][DRV_PEN];
        assign pull_sel[2*p +: 2]  = st_q.drv[p][DRV_PSEL_L +: 2];
    end

    logic [ADDR_W-1:0] off_drv, off_sns;
    logic              hit_drv, hit_sns;
    logic              hit_st0, hit_st1, hit_mk0, hit_mk1;
    logic              sel_st, sel_mk, clr;
    logic [BIT_W-1:0]  bp;
    logic [DATA_W-1:0] rd_val;
    logic              wdata_unused;

    assign wdata_unused = bus_wdata[DATA_W-1];

    always_comb begin
        st_d    = st_q;
        rd_val  = '0;
        off_drv = bus_addr - DRV_BASE;
        off_sns = bus_addr - SNS_BASE;
        hit_drv = (bus_addr >= DRV_BASE) && (off_drv < ADDR_W'(NUM_PINS));
        hit_sns = (bus_addr >= SNS_BASE) && (off_sns < ADDR_W'(NUM_PINS));
        hit_st0 = (bus_addr == STAT_BASE);
        hit_st1 = (bus_addr == STAT_BASE + ADDR_W'(1));
        hit_mk0 = (bus_addr == MASK_BASE);
        hit_mk1 = (bus_addr == MASK_BASE + ADDR_W'(1));
        sel_st  = 1'b0;
        sel_mk  = 1'b0;
        clr     = 1'b0;
        bp      = '0;

        for (int i = 0; i < NUM_PINS; i++) begin
            // drive register
            if (hit_drv && off_drv == ADDR_W'(i)) begin
                rd_val = DATA_W'(st_q.drv[i]);
                if (bus_wr) begin
                    st_d.drv[i] = bus_wdata[DRV_W-1:0];
                end
            end

            // sense register: mode writable, level read-only
            if (hit_sns && off_sns == ADDR_W'(i)) begin
                rd_val = DATA_W'({st_q.mode[i], level_w[i]});
                if (bus_wr) begin
                    st_d.mode[i] = edge_mode_e'(bus_wdata[2:1]);
                end
            end

            // group registers: bit position within its group
            sel_st = (i < GRP0_PINS) ? hit_st0 : hit_st1;
            sel_mk = (i < GRP0_PINS) ? hit_mk0 : hit_mk1;
            bp     = (i < GRP0_PINS) ? BIT_W'(i) : BIT_W'(i - GRP0_PINS);

            if (sel_st) begin
                rd_val[bp] = st_q.status[i];
            end
            if (sel_mk) begin
                rd_val[bp] = st_q.mask[i];
                if (bus_wr) begin
                    st_d.mask[i] = bus_wdata[bp];
                end
            end

            // sticky status, a new event wins over a clear
            clr            = bus_wr & sel_st & bus_wdata[bp];
            st_d.status[i] = (st_q.status[i] & ~clr) | evt_w[i];
        end

        st_d.rdata = bus_rd ? rd_val : st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |(st_q.status & ~st_q.mask);

    // flat views for the bound checker
    logic [NUM_PINS-1:0] status_w, mask_w;
    assign status_w = st_q.status;
    assign mask_w   = st_q.mask;

    if (GRP0_PINS > DATA_W || GRP1_PINS > DATA_W || GRP1_PINS < 1) begin : g_bad_split
        initial $error("group split does not fit the data width");
    end
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
    parameter int N = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         irq,
    input logic [N-1:0] pin_oe,
    input logic [N-1:0] pin_out,
    input logic [N-1:0] drv_pushpull,
    input logic [N-1:0] dir_vec,
    input logic [N-1:0] status_vec,
    input logic [N-1:0] mask_vec,
    input logic [N-1:0] evt_vec
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && status_vec == '0)) else $error("reset state"); // R1

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_out & ~drv_pushpull) == '0) else $error("open-drain drove high"); // R3

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_vec) == '0) else $error("input pin driven"); // R3

    AST_NO_SPURIOUS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vec & ~$past(status_vec)) & ~$past(evt_vec)) == '0) else $error("status set without edge"); // R6

    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((status_vec & $past(status_vec)) == $past(status_vec))) else $error("status dropped"); // R7

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((status_vec & $past(evt_vec)) == $past(evt_vec))) else $error("event lost"); // R8

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '1) |-> !irq) else $error("irq while all masked"); // R9

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec == '0) |-> !irq) else $error("irq without status"); // R9
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.N(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .irq          (irq),
    .pin_oe       (pin_oe),
    .pin_out      (pin_out),
    .drv_pushpull (drv_pushpull),
    .dir_vec      (dir_w),
    .status_vec   (status_w),
    .mask_vec     (mask_w),
    .evt_vec      (evt_w)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;
    localparam int NP = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe, pin_out, drv_pushpull, pull_en;
    logic [2*NP-1:0] pull_sel;
    logic          irq;

    int nchk = 0;
    int nerr = 0;

    logic [5:0]    m_drv [NP];
    logic [1:0]    m_mode[NP];
    logic [NP-1:0] m_stat = '0;
    logic [NP-1:0] m_mask = '1;
    logic [NP-1:0] m_lvl  = '0;

    always #4 clk = ~clk;

    gpio_edge_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .drv_pushpull(drv_pushpull),
        .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [15:0] a);
        for (int i = 0; i < NP; i++) begin
            if (a == 16'h4E44 + 16'(i)) return {2'b00, m_drv[i]};
            if (a == 16'h4E51 + 16'(i)) return {5'b0, m_mode[i], m_lvl[i]};
        end
        if (a == 16'h4E0B) return {1'b0, m_stat[6:0]};
        if (a == 16'h4E0C) return {2'b0, m_stat[12:7]};
        if (a == 16'h4E19) return {1'b0, m_mask[6:0]};
        if (a == 16'h4E1A) return {2'b0, m_mask[12:7]};
        return 8'h00;
    endfunction

    function automatic void model_write(logic [15:0] a, logic [7:0] d);
        for (int i = 0; i < NP; i++) begin
            if (a == 16'h4E44 + 16'(i)) m_drv[i] = d[5:0];
            if (a == 16'h4E51 + 16'(i)) m_mode[i] = d[2:1];
        end
        if (a == 16'h4E0B) m_stat[6:0]  = m_stat[6:0]  & ~d[6:0];
        if (a == 16'h4E0C) m_stat[12:7] = m_stat[12:7] & ~d[5:0];
        if (a == 16'h4E19) m_mask[6:0]  = d[6:0];
        if (a == 16'h4E1A) m_mask[12:7] = d[5:0];
    endfunction

    // all bus tasks start and end on a falling edge
    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [15:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(string req, logic [15:0] a);
        logic [7:0] d;
        bus_read(a, d);
        check(req, {16'h0, a[7:0], d}, {16'h0, a[7:0], exp_read(a)});
    endtask

    // apply new pin levels, update model, optionally wait for settling
    task automatic drive_pins(logic [NP-1:0] nv, bit settle);
        for (int i = 0; i < NP; i++) begin
            if (nv[i] != m_lvl[i]) begin
                if (( nv[i] && m_mode[i][1]) || (!nv[i] && m_mode[i][0]))
                    m_stat[i] = 1'b1;
            end
        end
        m_lvl  = nv;
        pin_in = nv;
        if (settle) repeat (4) @(negedge clk);
    endtask

    task automatic check_irq(string req);
        check(req, {31'h0, irq}, {31'h0, |(m_stat & ~m_mask)});
    endtask

    task automatic check_pads();
        logic [NP-1:0] e_oe, e_out, e_pp, e_pen;
        logic [2*NP-1:0] e_ps;
        for (int i = 0; i < NP; i++) begin
            e_oe[i]         = m_drv[i][5] & (m_drv[i][4] | ~m_drv[i][0]);
            e_out[i]        = m_drv[i][4] & m_drv[i][0];
            e_pp[i]         = m_drv[i][4];
            e_pen[i]        = m_drv[i][3];
            e_ps[2*i +: 2]  = m_drv[i][2:1];
        end
        check("R3 pin_oe", 32'(pin_oe), 32'(e_oe));
        check("R3 pin_out", 32'(pin_out), 32'(e_out));
        check("R3 drv_pushpull", 32'(drv_pushpull), 32'(e_pp));
        check("R3 pull_en", 32'(pull_en), 32'(e_pen));
        check("R3 pull_sel", 32'(pull_sel), 32'(e_ps));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        logic [7:0] d, d_prev;
        logic [15:0] a;
        for (int i = 0; i < NP; i++) begin m_drv[i] = '0; m_mode[i] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'h0, irq}, 32'h0);
        read_check("R1 mask0", 16'h4E19);
        check("R1 mask0 value", 32'(exp_read(16'h4E19)), 32'h7F);
        read_check("R1 mask1", 16'h4E1A);
        read_check("R1 status0", 16'h4E0B);
        read_check("R1 status1", 16'h4E0C);
        for (int i = 0; i < NP; i++) begin
            read_check("R1 drive", 16'h4E44 + 16'(i));
            read_check("R1 sense", 16'h4E51 + 16'(i));
        end
        check_pads();

        // R2 drive register, high bits read 0; R3 pad modes
        bus_write(16'h4E47, 8'hFF);
        bus_read(16'h4E47, d);
        check("R2 drive bits 7:6 read 0", 32'(d), 32'h3F);
        check_pads();
        bus_write(16'h4E45, 8'h20);                 // output, open-drain, level 0 -> drive low
        bus_write(16'h4E46, 8'h21);                 // output, open-drain, level 1 -> released
        bus_write(16'h4E48, 8'h11);                 // input, push-pull -> not driven
        bus_write(16'h4E50, 8'h2C);                 // output, open-drain, pull 50k down
        check("R3 od low drives", {31'h0, pin_oe[1]}, 32'h1);
        check("R3 od high releases", {31'h0, pin_oe[2]}, 32'h0);
        check("R3 input not driven", {31'h0, pin_oe[4]}, 32'h0);
        check_pads();

        // R4 sense register: bit0 read-only, high bits 0
        bus_write(16'h4E51, 8'hFF);
        bus_read(16'h4E51, d);
        check("R4 sense write 0xFF", 32'(d), 32'h06);

        // R5 read-back latency of pin level (pin 0 mode any edge)
        drive_pins(13'h0001, 1'b0);
        bus_read(16'h4E51, d);
        check("R5 level after 1 edge", 32'(d), 32'h06);
        bus_read(16'h4E51, d);
        check("R5 level after 2 edges", 32'(d), 32'h06);
        bus_read(16'h4E51, d);
        check("R5 level after 3 edges", 32'(d), 32'h07);
        repeat (2) @(negedge clk);
        read_check("R6 any-edge rise status", 16'h4E0B);

        // R6 every mode on pin 9 (group 1 bit 2), both directions
        for (int m = 0; m < 4; m++) begin
            bus_write(16'h4E0C, 8'h3F);
            bus_write(16'h4E5A, 8'(m << 1));
            drive_pins(m_lvl | 13'h0200, 1'b1);
            read_check("R6 rise per mode", 16'h4E0C);
            bus_write(16'h4E0C, 8'h3F);
            drive_pins(m_lvl & ~13'h0200, 1'b1);
            read_check("R6 fall per mode", 16'h4E0C);
        end

        // R7 write 0 keeps, write 1 clears
        check("R7 pin 9 pending", 32'(m_stat[9]), 32'h1);
        bus_write(16'h4E0C, 8'h00);
        read_check("R7 write 0 keeps", 16'h4E0C);
        bus_write(16'h4E0C, 8'h04);
        read_check("R7 write 1 clears", 16'h4E0C);
        check("R7 cleared in model", 32'(m_stat[9]), 32'h0);

        // R8 clear meets new edge in same cycle (pin 0, mode any)
        check("R8 precondition", 32'(m_stat[0]), 32'h1);
        drive_pins(m_lvl & ~13'h0001, 1'b0);
        @(negedge clk);
        @(negedge clk);
        bus_write(16'h4E0B, 8'h01);
        m_stat[0] = 1'b1;                           // the new edge wins
        read_check("R8 status survives clear", 16'h4E0B);

        // R9 mask and irq
        bus_write(16'h4E19, 8'h7F);
        bus_write(16'h4E1A, 8'h3F);
        @(negedge clk);
        check_irq("R9 irq masked");
        bus_write(16'h4E19, 8'h7E);
        @(negedge clk);
        check_irq("R9 irq unmasked");
        check("R9 irq high", {31'h0, irq}, 32'h1);
        bus_write(16'h4E0B, 8'h01);
        @(negedge clk);
        check_irq("R9 irq after clear");

        // R10 unused high bits
        bus_write(16'h4E1A, 8'hFF);
        read_check("R10 mask1 high bits", 16'h4E1A);
        bus_write(16'h4E19, 8'h80);
        read_check("R10 mask0 bit7", 16'h4E19);

        // R11 unmapped addresses
        bus_write(16'h4E43, 8'hFF);
        bus_write(16'h4E5E, 8'hFF);
        read_check("R11 neighbour of drive0 unchanged", 16'h4E44);
        read_check("R11 last sense unchanged", 16'h4E5D);
        read_check("R11 read 0x4E43", 16'h4E43);
        read_check("R11 read 0x4E0D", 16'h4E0D);
        read_check("R11 read 0x0000", 16'h0000);

        // R12 read data holds while strobe low
        bus_read(16'h4E47, d_prev);
        bus_addr = 16'h4E0B;
        repeat (3) @(negedge clk);
        check("R12 rdata held", 32'(bus_rdata), 32'(d_prev));

        // constrained random
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 5);
            case ($urandom % 6)
                0: a = 16'h4E44 + 16'($urandom % NP);
                1: a = 16'h4E51 + 16'($urandom % NP);
                2: a = 16'h4E0B + 16'($urandom % 2);
                3: a = 16'h4E19 + 16'($urandom % 2);
                4: a = 16'h4E00 + 16'($urandom % 128);
                default: a = 16'($urandom);
            endcase
            if (op < 2) begin
                bus_write(a, 8'($urandom));
                check_pads();
            end else if (op < 4) begin
                read_check("R7 random read", a);
            end else begin
                drive_pins(m_lvl ^ NP'($urandom), 1'b1);
                check_irq("R9 random irq");
            end
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule